// File: doc/BRIEF.md
# Sync-Aligned Clock Divider

This block divides a fast clock into a one-cycle-wide enable pulse whose phase can be forced back to a known point by an external synchronization pin. Software programs the divide ratio, the way the pin is interpreted (high level, rising edge or falling edge) and how pin events are allowed through. Pin events reach the divider only through two enable bits in a control register.

The pin is brought into the clock domain by two flip-flops before it is examined. A qualifying event clears the divider counter, so the enable pulse resumes at a fixed offset from the event. In continuous mode every qualifying event realigns the divider. In one-shot mode only the first event does, and the hardware then clears its own gate bit so that later events are ignored until software opens the gate again.

Registers are written through a simple single-cycle write strobe with a two-bit address. Readback is combinational on the same address.

Top module: `sync_clkdiv`

## Requirements
- R1: After reset every register reads 0 and `div_en` is held high, because the ratio field is 0 (divide by 1).
- R2: The ratio field is bits [2:0] of address 2. A value n makes `div_en` high for one cycle in every n+1 cycles. A value of 0 keeps `div_en` constantly high.
- R3: While bit 0 of the control register at address 0 (the master enable) is 0, no pin activity changes the divider phase.
- R4: While bit 1 of the control register (the divider gate) is 0, no pin activity changes the divider phase.
- R5: With bits 0 and 1 set and bit 2 clear (continuous mode), every qualifying event realigns the divider. If the pin is sampled at clock edge E1, the counter is zeroed at edge E3 and `div_en` is high in the cycle after E3.
- R6: With bits 0, 1 and 2 set (one-shot mode), the first qualifying event realigns the divider and clears bit 1 on the same edge, so address 0 then reads 0x05. Later events have no effect.
- R7: A write to address 0 on the same edge as a one-shot self-clear takes priority, and the written value is kept.
- R8: Unused bits read 0: bits [7:3] at address 0, bits [7:2] at address 1, bits [7:3] at address 2, and all of address 3.
- R9: With bit 0 of address 1 set to 0 (level mode) and the gate open in continuous mode, the counter is held at 0 for as long as the synchronized pin stays high, so `div_en` stays high.
- R10: With bit 0 of address 1 set to 1 and bit 1 set to 1, only a rising pin edge qualifies.
- R11: With bit 0 of address 1 set to 1 and bit 1 set to 0, only a falling pin edge qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | Asynchronous synchronization pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and readback |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Readback of the addressed register |
| div_en | output | 1 | Divided clock enable pulse |

## Verification
A register write takes effect on the edge that samples the strobe, and readback follows the address combinationally within the same cycle. A pin change sampled at edge E1 passes two synchronizer stages, becomes an event in the cycle after E2, and zeroes the counter at E3. `div_en` is therefore high in the cycle after E3, and in one-shot mode the gate bit reads 0 from that same cycle. The reference model in the bench keeps a short pin history and applies these delays edge by edge. Outputs are compared at every falling clock edge, half a cycle after the edge that produced them, and stimulus changes just after that comparison.

// File: rtl/sync_clkdiv.sv
module sync_clkdiv #(
  parameter int DIVW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_pin,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       div_en
);

  logic [2:0]      ctrl;
  logic [1:0]      pcfg;
  logic [DIVW-1:0] ratio;
  logic [DIVW-1:0] cnt;
  logic            s1, s2, s3;

  wire master  = ctrl[0];
  wire gate    = ctrl[1];
  wire oneshot = ctrl[2];
  wire wr_ctrl = wr_en && (addr == 2'd0);

  wire edge_hit = pcfg[1] ? (s2 && !s3) : (!s2 && s3);
  wire evt      = pcfg[0] ? edge_hit : s2;
  wire qual     = evt && master && gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sync_pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      pcfg  <= '0;
      ratio <= '0;
    end else begin
      if (wr_ctrl)
        ctrl <= wdata[2:0];
      else if (qual && oneshot)
        ctrl[1] <= 1'b0;
      if (wr_en && addr == 2'd1) pcfg  <= wdata[1:0];
      if (wr_en && addr == 2'd2) ratio <= wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (qual || cnt >= ratio)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign div_en = (cnt == '0);

  always_comb begin
    case (addr)
      2'd0:    rdata = {5'b0, ctrl};
      2'd1:    rdata = {6'b0, pcfg};
      2'd2:    rdata = {{(8-DIVW){1'b0}}, ratio};
      default: rdata = 8'h00;
    endcase
  end

  AST_RATIO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == '0 && $past(ratio) == '0) |-> div_en);  // R2

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(master && gate) && cnt < ratio) |=> cnt == DIVW'($past(cnt) + 1'b1));  // R3

  AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> div_en);  // R5

  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && oneshot && !wr_ctrl) |=> !gate);  // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl == $past(wdata[2:0]));  // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> rdata == 8'h00);  // R8

endmodule

// File: tb/sync_clkdiv_test.sv
`timescale 1ns/100ps
module sync_clkdiv_test;
  logic clk = 0, rst_n = 0, sync_pin = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic div_en;

  int total = 0, bad = 0;
  bit live = 0;
  string cur_req = "R1";

  int m_ctrl, m_cfg, m_ratio, m_cnt;
  int ph[$];

  sync_clkdiv uut (.clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .div_en(div_en));

  always #2 clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_cfg;
      2: return m_ratio;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cfg = 0; m_ratio = 0; m_cnt = 0;
      ph = '{0, 0, 0};
    end else begin
      int s2, s3, ev, q;
      s2 = ph[ph.size()-2];
      s3 = ph[ph.size()-3];
      if (m_cfg[0] == 0) ev = s2;
      else if (m_cfg[1]) ev = (s2 == 1 && s3 == 0);
      else ev = (s2 == 0 && s3 == 1);
      q = ev && m_ctrl[0] && m_ctrl[1];
      if (q || m_cnt >= m_ratio) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (wr_en && addr == 0) m_ctrl = wdata & 7;
      else if (q && m_ctrl[2]) m_ctrl = m_ctrl & 5;
      if (wr_en && addr == 1) m_cfg = wdata & 3;
      if (wr_en && addr == 2) m_ratio = wdata & 7;
      ph.push_back(int'(sync_pin));
      void'(ph.pop_front());
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check({cur_req, " div_en"}, int'(div_en), int'(m_cnt == 0));
      check({cur_req, " rdata"}, int'(rdata), exp_rd(int'(addr)));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = a[1:0]; wdata = d[7:0];
    tick();
    wr_en = 0;
  endtask

  task automatic rd_check(string req, int a, int exp);
    addr = a[1:0];
    #0.2;
    check(req, int'(rdata), exp);
  endtask

  task automatic pulse(int width, int gap);
    sync_pin = 1; tick(width);
    sync_pin = 0; tick(gap);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    tick(2);
    rst_n = 1;
    #0.2;
    for (int a = 0; a < 4; a++) rd_check("R1 reset readback", a, 0);
    check("R1 reset div_en", int'(div_en), 1);
    live = 1;
    tick(3);

    cur_req = "R2";
    wr(2, 3); tick(20);
    wr(2, 7); tick(20);
    wr(2, 0); tick(6);
    check("R2 ratio one", int'(div_en), 1);
    wr(2, 3); tick(5);

    wr(1, 8'h03);
    cur_req = "R3";
    wr(0, 8'h02); pulse(2, 6); pulse(1, 7);
    cur_req = "R4";
    wr(0, 8'h05); pulse(2, 5); pulse(3, 6);

    cur_req = "R5";
    wr(0, 8'h03);
    tick(1); pulse(1, 9);
    tick(2); pulse(2, 6);
    sync_pin = 1; tick(3);
    check("R5 realign due", int'(div_en), 1);
    sync_pin = 0; tick(8);
    cur_req = "R10";
    pulse(1, 3); pulse(4, 5);

    cur_req = "R11";
    wr(1, 8'h01);
    pulse(2, 7); tick(1); pulse(3, 9);

    cur_req = "R9";
    wr(1, 8'h00);
    tick(2); sync_pin = 1; tick(12); sync_pin = 0; tick(8);

    cur_req = "R6";
    wr(1, 8'h03);
    wr(0, 8'h07);
    tick(1); pulse(1, 6);
    rd_check("R6 gate self-cleared", 0, 8'h05);
    pulse(1, 6); tick(2); pulse(2, 7);
    rd_check("R6 later events ignored", 0, 8'h05);

    cur_req = "R7";
    wr(0, 8'h07);
    tick(2);
    sync_pin = 1;
    tick(2);
    wr(0, 8'h07);
    rd_check("R7 write wins over clear", 0, 8'h07);
    sync_pin = 0; tick(10);

    cur_req = "R8";
    wr(0, 8'hF8);
    rd_check("R8 control reserved", 0, 8'h00);
    wr(1, 8'hFC);
    rd_check("R8 config reserved", 1, 8'h00);
    wr(2, 8'hF8);
    rd_check("R8 ratio reserved", 2, 8'h00);
    wr(3, 8'hFF);
    rd_check("R8 address 3", 3, 8'h00);
    wr(0, 8'hFF);
    rd_check("R8 control upper bits", 0, 8'h07);
    tick(4);

    live = 0;
    finish_up();
  end
endmodule